// File: doc/BRIEF.md
# SDRAM Burst-Read Command Sequencer

This block is the read side of an SDRAM controller. A host presents a byte address, an access size and a line-fill flag. The block turns that request into a row activation followed by a run of single-beat column reads. The SDRAM is always programmed for burst length 1, so any transfer wider than the data bus becomes several consecutive read commands. The final read of the run carries auto-precharge. The beats that return are packed little-endian into one response word, and that word is presented to the host with a one-cycle valid strobe.

After the closing auto-precharge read, the bank that was just used stays locked for a programmable number of wait cycles. The lock applies only to that bank. A request to any other bank can open its row straight away, while the data of the previous request is still returning.

Top module: `sdram_rd_seq`

## Requirements
- R1: After synchronous reset, `sd_cmd` is NOP, `ack` and `rsp_valid` are low, and no bank is locked, so the first request is acknowledged one cycle after it is presented.
- R2: The number of column reads per request follows `req_size` (0 = byte, 1 = halfword, 2 or 3 = word) and `req_line` (16-byte line, overrides size). On a 16-bit bus this gives 1, 1, 2 and 8 reads for byte, halfword, word and line. On a 32-bit bus it gives 1, 1, 1 and 4.
- R3: `sd_cmd` encodes 0 = NOP, 1 = activate, 2 = read, 3 = read with auto-precharge. Activate comes first. The reads follow in consecutive cycles, with code 2 on every read but the last and code 3 on the last. NOP is driven whenever nothing is issued.
- R4: The byte address is split, from the least significant bit up, into log2(bus bytes) lane bits, COL_W column bits, BANK_W bank bits and ROW_W row bits. `sd_bank` and `sd_row` carry the fields during activate. The first column equals the column field rounded down to a multiple of the read count, and each later read increases it by one bus word.
- R5: The data bus is sampled at the end of the cycle that lies CAS_LAT (2) cycles after each read command. Beat i is placed at bits [i*DATA_W +: DATA_W] of `rsp_data`, and bits above the last beat are zero.
- R6: `rsp_valid` is a single-cycle pulse in the third cycle after the auto-precharge read. `rsp_data` holds its value until the next pulse.
- R7: A request is accepted only when no sequence is in progress and its bank is not locked. `req` is ignored otherwise. `ack` is a one-cycle pulse in the same cycle as the activate.
- R8: With `tap_cfg` = n and an auto-precharge read in cycle e, an activate to the same bank appears no earlier than cycle e+1+n.
- R9: A request to a different bank, held from the cycle of the auto-precharge read, is activated in cycle e+1.
- R10: With `tap_cfg` = 0, a request to the same bank is activated in cycle e+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Read request, held until `ack` |
| req_addr | input | ADDR_W | Byte address of the request |
| req_size | input | 2 | Access size code |
| req_line | input | 1 | 16-byte line transfer |
| tap_cfg | input | 2 | Wait cycles after auto-precharge read |
| ack | output | 1 | Request accepted |
| rsp_valid | output | 1 | Response complete |
| rsp_data | output | 128 | Packed response beats |
| sd_cmd | output | 2 | SDRAM command code |
| sd_bank | output | BANK_W | Bank address |
| sd_row | output | ROW_W | Row address |
| sd_col | output | COL_W | Column address in bus words |
| sd_dq | input | DATA_W | SDRAM read data |

## Verification
A wrong beat counter shows up at once on `sd_cmd`: the auto-precharge code lands one cycle early or late, and the response pulse moves with it three cycles later. A slipped capture pipeline stage or a bad beat index shows up in `rsp_data` at the next response, as a beat that is misplaced or missing. A corrupt lockout counter shows up only on the next request to the same or another bank. There the activate comes too soon or too late against the cycle computed from `tap_cfg`. This is why the stimulus mixes same-bank and cross-bank requests presented right at the auto-precharge cycle.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'd0,
    CMD_ACTV  = 2'd1,
    CMD_READ  = 2'd2,
    CMD_READA = 2'd3
  } sd_cmd_e;

  localparam int LINE_BITS = 128;

  // Number of single-beat reads needed for one host request.
  function automatic logic [4:0] beat_count(input logic [1:0] size,
                                            input logic line,
                                            input int bus_bytes);
    int nbytes;
    if (line)              nbytes = 16;
    else if (size == 2'd0) nbytes = 1;
    else if (size == 2'd1) nbytes = 2;
    else                   nbytes = 4;
    if (nbytes <= bus_bytes) return 5'd1;
    return 5'(nbytes / bus_bytes);
  endfunction

endpackage

// File: rtl/sdram_rd_ctrl.sv
module sdram_rd_ctrl
  import sdram_rd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COL_W  = 8,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12,
  localparam int LANE_W = $clog2(DATA_W / 8),
  localparam int ADDR_W = LANE_W + COL_W + BANK_W + ROW_W,
  localparam int BEAT_W = $clog2(LINE_BITS / DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_line,
  input  logic              bank_locked,
  output logic              ack_o,
  output sd_cmd_e           cmd_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o,
  output logic [BEAT_W-1:0] beat_o
);

  localparam int BUS_BYTES = DATA_W / 8;

  logic              busy_q;
  logic [4:0]        left_q;
  logic [COL_W-1:0]  col_cur_q;
  logic [BEAT_W-1:0] beat_nxt_q;

  logic [4:0]        nbeats;
  logic [COL_W-1:0]  col_field;
  logic [COL_W-1:0]  col_start;

  always_comb begin
    nbeats    = beat_count(req_size, req_line, BUS_BYTES);
    col_field = req_addr[LANE_W +: COL_W];
    col_start = col_field & ~COL_W'(nbeats - 5'd1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      left_q     <= '0;
      col_cur_q  <= '0;
      beat_nxt_q <= '0;
      ack_o      <= 1'b0;
      cmd_o      <= CMD_NOP;
      bank_o     <= '0;
      row_o      <= '0;
      col_o      <= '0;
      beat_o     <= '0;
    end else begin
      ack_o <= 1'b0;
      cmd_o <= CMD_NOP;
      if (!busy_q) begin
        if (req && !bank_locked) begin
          busy_q     <= 1'b1;
          ack_o      <= 1'b1;
          cmd_o      <= CMD_ACTV;
          bank_o     <= req_addr[LANE_W + COL_W +: BANK_W];
          row_o      <= req_addr[LANE_W + COL_W + BANK_W +: ROW_W];
          col_cur_q  <= col_start;
          left_q     <= nbeats;
          beat_nxt_q <= '0;
        end
      end else begin
        cmd_o      <= (left_q == 5'd1) ? CMD_READA : CMD_READ;
        col_o      <= col_cur_q;
        beat_o     <= beat_nxt_q;
        col_cur_q  <= col_cur_q + 1'b1;
        beat_nxt_q <= beat_nxt_q + 1'b1;
        left_q     <= left_q - 5'd1;
        if (left_q == 5'd1) busy_q <= 1'b0;
      end
    end
  end

  // R3: an activate is always followed by a column read
  a_r3_actv_then_read: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == CMD_ACTV) |=> (cmd_o == CMD_READ || cmd_o == CMD_READA));

  // R3: after the auto-precharge read no plain read follows
  a_r3_reada_closes: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == CMD_READA) |=> (cmd_o == CMD_NOP || cmd_o == CMD_ACTV));

  // R4: consecutive reads step the column by one word in the same bank
  a_r4_col_step: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == CMD_READ) |=> (col_o == $past(col_o) + 1'b1) && $stable(bank_o));

  // R7: acknowledge is a single-cycle pulse
  a_r7_ack_pulse: assert property (@(posedge clk) disable iff (rst)
    ack_o |=> !ack_o);

endmodule

// File: rtl/sdram_rd_lockout.sv
module sdram_rd_lockout
  import sdram_rd_pkg::*;
#(
  parameter int BANK_W = 2,
  localparam int NBANK = 1 << BANK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        tap_cfg,
  input  sd_cmd_e           cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [BANK_W-1:0] query_bank,
  output logic              locked_o
);

  logic [1:0]       cnt_q [NBANK];
  logic [NBANK-1:0] lock_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < NBANK; b++) cnt_q[b] <= '0;
    end else begin
      for (int b = 0; b < NBANK; b++) begin
        if (cmd_i == CMD_READA && bank_i == BANK_W'(b))
          cnt_q[b] <= (tap_cfg == 2'd0) ? 2'd0 : tap_cfg - 2'd1;
        else if (cnt_q[b] != 2'd0)
          cnt_q[b] <= cnt_q[b] - 2'd1;
      end
    end
  end

  // A bank is locked in the auto-precharge cycle itself (non-zero wait)
  // and for the remaining wait cycles held in its counter.
  for (genvar g = 0; g < NBANK; g++) begin : g_lock
    assign lock_vec[g] = (cnt_q[g] != 2'd0) ||
                         (cmd_i == CMD_READA && bank_i == BANK_W'(g) && tap_cfg != 2'd0);
  end

  assign locked_o = lock_vec[query_bank];

  // R8: an activate never reaches a bank whose wait is still running
  a_r8_actv_unlocked: assert property (@(posedge clk) disable iff (rst)
    (cmd_i == CMD_ACTV) |-> (cnt_q[bank_i] == 2'd0));

endmodule

// File: rtl/sdram_rd_capture.sv
module sdram_rd_capture
  import sdram_rd_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int CAS_LAT = 2,
  localparam int BEAT_W = $clog2(LINE_BITS / DATA_W)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  sd_cmd_e              cmd_i,
  input  logic [BEAT_W-1:0]    beat_i,
  input  logic [DATA_W-1:0]    dq_i,
  output logic                 rsp_valid_o,
  output logic [LINE_BITS-1:0] rsp_data_o
);

  logic [CAS_LAT-1:0] pv_q;
  logic [CAS_LAT-1:0] pl_q;
  logic [BEAT_W-1:0]  pb_q [CAS_LAT];
  logic [LINE_BITS-1:0] asm_q;
  logic [LINE_BITS-1:0] asm_next;
  logic [BEAT_W-1:0]    cap_beat;

  assign cap_beat = pb_q[CAS_LAT-1];

  always_comb begin
    asm_next = (cap_beat == '0) ? '0 : asm_q;
    asm_next[int'(cap_beat) * DATA_W +: DATA_W] = dq_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pv_q        <= '0;
      pl_q        <= '0;
      for (int s = 0; s < CAS_LAT; s++) pb_q[s] <= '0;
      asm_q       <= '0;
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      pv_q[0] <= (cmd_i == CMD_READ) || (cmd_i == CMD_READA);
      pl_q[0] <= (cmd_i == CMD_READA);
      pb_q[0] <= beat_i;
      for (int s = 1; s < CAS_LAT; s++) begin
        pv_q[s] <= pv_q[s-1];
        pl_q[s] <= pl_q[s-1];
        pb_q[s] <= pb_q[s-1];
      end
      rsp_valid_o <= 1'b0;
      if (pv_q[CAS_LAT-1]) begin
        asm_q <= asm_next;
        if (pl_q[CAS_LAT-1]) begin
          rsp_data_o  <= asm_next;
          rsp_valid_o <= 1'b1;
        end
      end
    end
  end

  // R6: completion strobe lasts one cycle
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_o |=> !rsp_valid_o);

  // R6: response word changes only together with the strobe
  a_r6_data_hold: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid_o |-> $stable(rsp_data_o));

  // R5: a beat is captured only from a stage filled by a read command
  a_r5_last_is_beat: assert property (@(posedge clk) disable iff (rst)
    pl_q[CAS_LAT-1] |-> pv_q[CAS_LAT-1]);

endmodule

// File: rtl/sdram_rd_seq.sv
module sdram_rd_seq
  import sdram_rd_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int COL_W   = 8,
  parameter int BANK_W  = 2,
  parameter int ROW_W   = 12,
  parameter int CAS_LAT = 2,
  localparam int LANE_W = $clog2(DATA_W / 8),
  localparam int ADDR_W = LANE_W + COL_W + BANK_W + ROW_W,
  localparam int BEAT_W = $clog2(LINE_BITS / DATA_W)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [1:0]           req_size,
  input  logic                 req_line,
  input  logic [1:0]           tap_cfg,
  output logic                 ack,
  output logic                 rsp_valid,
  output logic [LINE_BITS-1:0] rsp_data,
  output logic [1:0]           sd_cmd,
  output logic [BANK_W-1:0]    sd_bank,
  output logic [ROW_W-1:0]     sd_row,
  output logic [COL_W-1:0]     sd_col,
  input  logic [DATA_W-1:0]    sd_dq
);

  sd_cmd_e           cmd;
  logic [BEAT_W-1:0] beat;
  logic              bank_locked;
  logic [BANK_W-1:0] req_bank;

  assign req_bank = req_addr[LANE_W + COL_W +: BANK_W];
  assign sd_cmd   = cmd;

  sdram_rd_ctrl #(
    .DATA_W(DATA_W), .COL_W(COL_W), .BANK_W(BANK_W), .ROW_W(ROW_W)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .req        (req),
    .req_addr   (req_addr),
    .req_size   (req_size),
    .req_line   (req_line),
    .bank_locked(bank_locked),
    .ack_o      (ack),
    .cmd_o      (cmd),
    .bank_o     (sd_bank),
    .row_o      (sd_row),
    .col_o      (sd_col),
    .beat_o     (beat)
  );

  sdram_rd_lockout #(.BANK_W(BANK_W)) u_lock (
    .clk       (clk),
    .rst       (rst),
    .tap_cfg   (tap_cfg),
    .cmd_i     (cmd),
    .bank_i    (sd_bank),
    .query_bank(req_bank),
    .locked_o  (bank_locked)
  );

  sdram_rd_capture #(.DATA_W(DATA_W), .CAS_LAT(CAS_LAT)) u_cap (
    .clk        (clk),
    .rst        (rst),
    .cmd_i      (cmd),
    .beat_i     (beat),
    .dq_i       (sd_dq),
    .rsp_valid_o(rsp_valid),
    .rsp_data_o (rsp_data)
  );

endmodule

// File: tb/test_sdram_rd_seq.sv
`timescale 1ns/1ps
module test_sdram_rd_seq;

  localparam int DW = 16;
  localparam int AW = 23;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = '0;
  logic          req_line = 1'b0;
  logic [1:0]    tap_cfg = '0;
  logic          ack, rsp_valid;
  logic [127:0]  rsp_data;
  logic [1:0]    sd_cmd;
  logic [1:0]    sd_bank;
  logic [11:0]   sd_row;
  logic [7:0]    sd_col;
  logic [DW-1:0] sd_dq = '0;

  sdram_rd_seq #(.DATA_W(DW)) i_sdram_rd_seq (
    .clk(clk), .rst(rst), .req(req), .req_addr(req_addr), .req_size(req_size),
    .req_line(req_line), .tap_cfg(tap_cfg), .ack(ack), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .sd_cmd(sd_cmd), .sd_bank(sd_bank), .sd_row(sd_row),
    .sd_col(sd_col), .sd_dq(sd_dq)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] data_of(input logic [1:0] b, input logic [11:0] r,
                                            input logic [7:0] c);
    logic [31:0] h;
    h = {30'd0, b} * 32'h0001_F3A1 + {20'd0, r} * 32'h9E37_79B1 + {24'd0, c} * 32'h2B4D + 32'h5A5;
    return h[15:0] ^ h[31:16];
  endfunction

  function automatic int beats_of(input logic [1:0] s, input logic l);
    int nb;
    if (l) nb = 16;
    else if (s == 2'd0) nb = 1;
    else if (s == 2'd1) nb = 2;
    else nb = 4;
    return (nb <= 2) ? 1 : nb / 2;
  endfunction

  // SDRAM data model: data for a read in cycle x is driven during cycle x+2
  logic [1:0]    mon_bank = '0;
  logic [11:0]   mon_row = '0;
  logic [DW-1:0] p1 = '0, p2 = '0;
  always @(negedge clk) begin
    sd_dq = p2;
    p2 = p1;
    if (sd_cmd == 2'd1) begin
      mon_bank = sd_bank;
      mon_row  = sd_row;
    end
    p1 = (sd_cmd == 2'd2 || sd_cmd == 2'd3) ? data_of(mon_bank, mon_row, sd_col) : 16'hDEAD;
  end

  // Expected responses
  logic [127:0] exp_data [64];
  int           exp_cyc  [64];
  int wr_p = 0, rd_p = 0;
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (rd_p == wr_p) chk(1'b0, "R6 unexpected response", 128'(cyc), 0);
      else begin
        chk(rsp_data == exp_data[rd_p % 64], "R5 response data", rsp_data, exp_data[rd_p % 64]);
        chk(cyc == exp_cyc[rd_p % 64], "R6 response cycle", 128'(cyc), 128'(exp_cyc[rd_p % 64]));
        rd_p++;
      end
    end
  end

  int unlock [4] = '{0, 0, 0, 0};
  int last_e = 0;

  // Presents one request, checks its command stream; returns in the READA cycle.
  task automatic run_req(input logic [AW-1:0] a, input logic [1:0] s, input logic l,
                         input string tag);
    int nb, call, ack_c, exp_ack;
    logic [1:0] b;
    logic [11:0] r;
    logic [7:0] c0;
    logic [127:0] ed;
    bit got;
    nb = beats_of(s, l);
    b  = a[10:9];
    r  = a[22:11];
    c0 = a[8:1] & ~8'(nb - 1);
    call = cyc;
    exp_ack = call + 1;
    if (unlock[b] > exp_ack) exp_ack = unlock[b];
    req = 1'b1; req_addr = a; req_size = s; req_line = l;
    got = 1'b0;
    while (!got) begin
      @(negedge clk);
      got = ack;
    end
    ack_c = cyc;
    req = 1'b0;
    chk(ack_c == exp_ack, {tag, " R7 ack cycle"}, 128'(ack_c), 128'(exp_ack));
    chk(sd_cmd == 2'd1 && sd_bank == b && sd_row == r, {tag, " R4 activate"},
        {sd_cmd, sd_bank, sd_row}, {2'd1, b, r});
    ed = '0;
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      chk(sd_cmd == ((i == nb - 1) ? 2'd3 : 2'd2) && !ack, {tag, " R2 R3 read code"},
          128'(sd_cmd), 128'((i == nb - 1) ? 3 : 2));
      chk(sd_col == 8'(c0 + i), {tag, " R4 column"}, 128'(sd_col), 128'(8'(c0 + i)));
      ed[i*DW +: DW] = data_of(b, r, 8'(c0 + i));
    end
    last_e = cyc;
    unlock[b] = last_e + 1 + int'(tap_cfg);
    exp_data[wr_p % 64] = ed;
    exp_cyc[wr_p % 64]  = last_e + 3;
    wr_p++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    for (int w = 0; w < 20000; w++) @(posedge clk);
    chk(1'b0, "watchdog", 128'(cyc), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(sd_cmd == 2'd0 && !ack && !rsp_valid, "R1 reset outputs",
        {ack, rsp_valid, sd_cmd}, 0);
    tap_cfg = 2'd3;
    run_req(23'h00_0200, 2'd0, 1'b0, "R1 first");
    idle(6);

    // R2: each size and the line fill
    run_req(23'h12_3456, 2'd0, 1'b0, "R2 byte");   idle(6);
    run_req(23'h12_3456, 2'd1, 1'b0, "R2 half");   idle(6);
    run_req(23'h12_345E, 2'd2, 1'b0, "R2 word");   idle(6);
    run_req(23'h12_345E, 2'd3, 1'b0, "R2 word3");  idle(6);
    run_req(23'h45_67FE, 2'd1, 1'b1, "R2 line");   idle(6);
    chk(sd_cmd == 2'd0, "R3 nop when idle", 128'(sd_cmd), 0);

    // R8 R10: same bank right after the auto-precharge read, each wait value
    for (int t = 0; t < 4; t++) begin
      tap_cfg = 2'(t);
      run_req(23'h01_0202, 2'd1, 1'b0, "R8 first");
      run_req(23'h02_0204, 2'd0, 1'b0, t == 0 ? "R10 same bank" : "R8 same bank");
      idle(6);
    end
    // R9: other bank starts in the next cycle even with the longest wait
    tap_cfg = 2'd3;
    run_req(23'h01_0202, 2'd2, 1'b0, "R9 first");
    run_req(23'h01_0602, 2'd1, 1'b1, "R9 other bank");
    idle(12);

    // Random mix, back to back or with short gaps
    for (int k = 0; k < 60; k++) begin
      logic [AW-1:0] a;
      logic [1:0] s;
      logic l;
      a = AW'($urandom);
      s = 2'($urandom);
      l = ($urandom % 4) == 0;
      if ((k % 15) == 0) begin
        idle(12);
        tap_cfg = 2'($urandom);
      end
      run_req(a, s, l, "R2 R8 random");
      idle(int'($urandom % 3));
    end
    idle(12);
    chk(rd_p == wr_p, "R6 all responses seen", 128'(rd_p), 128'(wr_p));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule